// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a virtual address into a physical address. It walks a four-level radix table held in memory, one 64-bit entry at a time. A start pulse captures the virtual address, the root table base and the no-execute enable. The walker checks that the address is canonical. It then issues one read per level through a valid/ready request port and consumes a single-beat read response for each read. Each entry is tested for presence and for reserved bits. The walk ends on a leaf of 1 GB, 2 MB or 4 KB.

On its way down the walker writes back the accessed flag of any non-leaf entry that has it clear. It also folds the user, write and no-execute flags of every level into one attribute set. A single-cycle done pulse reports the result, which is either a physical address with its page size and merged attributes or a fault code. The permission decision is made by a separate checker, which takes the merged attributes from this block.

Entry layout used throughout: bit 0 present, bit 1 writable, bit 2 user, bit 5 accessed, bit 7 page size, bit 63 no-execute, and bits 51:12 the next-table or page address. Fault codes: 0 none, 1 not present, 2 reserved bit, 3 non-canonical. Page size codes: 0 is 4 KB, 1 is 2 MB, 2 is 1 GB.

Top module: `pt_walker`

## Requirements
- R1: The entry read at level L (0 = top) is at the table base plus 8 times the index, where the index is virtual address bits 47:39, 38:30, 29:21 and 20:12 for levels 0 to 3. The level-0 base is root bits 51:12, and each later base is bits 51:12 of the previous entry.
- R2: If virtual address bits 63:47 are not all equal, the walk ends with fault code 3 and makes no memory request.
- R3: An entry with bit 0 clear ends the walk with fault code 1.
- R4: An entry ends the walk with fault code 2 if any address bit from the configured physical width up to bit 51 is set, or if bit 63 is set while no-execute is disabled.
- R5: A level-0 entry with bit 7 set ends the walk with fault code 2.
- R6: Bit 7 set at level 1 gives a 1 GB leaf (size code 2). Bit 7 set at level 2 gives a 2 MB leaf (size code 1). Otherwise the level-3 entry gives a 4 KB page (size code 0).
- R7: A large leaf with any of bits 29:13 (1 GB) or 20:13 (2 MB) set ends with fault code 2. Bit 12 is allowed.
- R8: A non-leaf entry with bit 5 clear is written back to its own address with bit 5 set, and all other bits unchanged, before the next level is read. Entries with bit 5 set are not written.
- R9: The user and write outputs are the AND of bits 2 and 1 over all levels walked. The no-execute output is the OR of bit 63 over those levels.
- R10: On success the physical address is the leaf's bits 51:12 with the bits below the page size cleared, ORed with the same low bits of the virtual address.
- R11: A request is held with stable address and type until accepted. No request is issued while a read is outstanding. The done pulse lasts exactly one cycle, after which the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (accepted when idle) |
| vaddr_i | input | 64 | Virtual address to translate |
| root_i | input | 52 | Root table base (bits 11:0 ignored) |
| nx_en_i | input | 1 | No-execute enable |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | 1 = write-back, 0 = read |
| mem_req_addr_o | output | 52 | Entry byte address |
| mem_req_wdata_o | output | 64 | Write-back data |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 64 | Read response data |
| done_o | output | 1 | Walk finished (one-cycle pulse) |
| fault_o | output | 2 | Fault code |
| paddr_o | output | 52 | Translated physical address |
| page_size_o | output | 2 | Page size code |
| user_o | output | 1 | Merged user permission |
| write_o | output | 1 | Merged write permission |
| nx_o | output | 1 | Merged no-execute |

## Verification
The bench aims at the points where a walker goes wrong quietly. A page-size bit on the top level must fault and must not make a 512 GB leaf. Bit 12 of a large leaf must be accepted, while bit 13 faults. A no-execute bit must be reserved only while the enable is off. A design that mixed up these rules would return a translation where a fault is due, or the reverse. Walks with the accessed bits clear on every level expose a missing or misplaced write-back: the write count and the memory image would differ from the model's. A high-half canonical address and a non-canonical one check the sign-extension test, and a design that checked the wrong bit would translate or issue reads when it should not. A run with a stalling request port shows whether a dropped or changed request breaks the read sequence.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int VA_W    = 64;
  localparam int VA_IMPL = 48;
  localparam int PA_W    = 52;
  localparam int ENT_W   = 64;
  localparam int IDX_W   = 9;
  localparam int PG_SH   = 12;

  localparam int B_PRES = 0;
  localparam int B_WR   = 1;
  localparam int B_USER = 2;
  localparam int B_ACC  = 5;
  localparam int B_PS   = 7;
  localparam int B_NX   = 63;

  typedef enum logic [2:0] {ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_FIN} wstate_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_NOTPRES = 2'd1, FLT_RSVD = 2'd2, FLT_CANON = 2'd3} fault_e;
  typedef enum logic [1:0] {SZ_4K = 2'd0, SZ_2M = 2'd1, SZ_1G = 2'd2} psize_e;

  function automatic logic is_canon(input logic [VA_W-1:0] va);
    return (&va[VA_W-1:VA_IMPL-1]) | ~(|va[VA_W-1:VA_IMPL-1]);
  endfunction

  function automatic logic [PA_W-1:0] tbl_addr(input logic [PA_W-1:0] base,
                                               input logic [VA_IMPL-1:0] va,
                                               input logic [1:0] lvl);
    logic [IDX_W-1:0] idx;
    case (lvl)
      2'd0:    idx = va[47:39];
      2'd1:    idx = va[38:30];
      2'd2:    idx = va[29:21];
      default: idx = va[20:12];
    endcase
    return {base[PA_W-1:PG_SH], idx, 3'b000};
  endfunction

  function automatic logic [ENT_W-1:0] rsvd_mask(input int phys_bits, input logic [1:0] lvl,
                                                 input logic ps, input logic nxe);
    logic [ENT_W-1:0] m;
    m = '0;
    for (int i = 0; i < PA_W; i++) if (i >= phys_bits) m[i] = 1'b1;
    m[B_NX] = ~nxe;
    if (lvl == 2'd0) m[B_PS] = 1'b1;
    if (ps && lvl == 2'd1) m[29:13] = '1;
    if (ps && lvl == 2'd2) m[20:13] = '1;
    return m;
  endfunction

  function automatic logic [PA_W-1:0] leaf_paddr(input logic [ENT_W-1:0] ent,
                                                 input logic [VA_IMPL-1:0] va,
                                                 input psize_e sz);
    case (sz)
      SZ_1G:   return {ent[PA_W-1:30], va[29:0]};
      SZ_2M:   return {ent[PA_W-1:21], va[20:0]};
      default: return {ent[PA_W-1:PG_SH], va[PG_SH-1:0]};
    endcase
  endfunction
endpackage

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walker_pkg::*;
#(
  parameter int PHYS_BITS = 46
) (
  input  logic [ENT_W-1:0] entry_i,
  input  logic [1:0]       lvl_i,
  input  logic             nxe_i,
  output logic             present_o,
  output logic             rsvd_o,
  output logic             leaf_o,
  output psize_e           size_o
);
  logic ps;
  assign ps        = entry_i[B_PS];
  assign present_o = entry_i[B_PRES];
  assign rsvd_o    = |(entry_i & rsvd_mask(PHYS_BITS, lvl_i, ps, nxe_i));
  assign leaf_o    = (lvl_i == 2'd3) || (ps && (lvl_i != 2'd0));

  always_comb begin
    case (lvl_i)
      2'd1:    size_o = SZ_1G;
      2'd2:    size_o = SZ_2M;
      default: size_o = SZ_4K;
    endcase
  end
endmodule

// File: rtl/pt_attr_acc.sv
module pt_attr_acc (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic upd_i,
  input  logic user_i,
  input  logic write_i,
  input  logic nx_i,
  output logic user_o,
  output logic write_o,
  output logic nx_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_o  <= 1'b0;
      write_o <= 1'b0;
      nx_o    <= 1'b0;
    end else if (clr_i) begin
      user_o  <= 1'b1;
      write_o <= 1'b1;
      nx_o    <= 1'b0;
    end else if (upd_i) begin
      user_o  <= user_o & user_i;
      write_o <= write_o & write_i;
      nx_o    <= nx_o | nx_i;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int PHYS_BITS = 46
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [PA_W-1:0]   root_i,
  input  logic              nx_en_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_we_o,
  output logic [PA_W-1:0]   mem_req_addr_o,
  output logic [ENT_W-1:0]  mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [ENT_W-1:0]  mem_rsp_data_i,
  output logic              done_o,
  output logic [1:0]        fault_o,
  output logic [PA_W-1:0]   paddr_o,
  output logic [1:0]        page_size_o,
  output logic              user_o,
  output logic              write_o,
  output logic              nx_o
);
  wstate_e              state_q;
  logic [1:0]           lvl_q;
  logic [PA_W-1:0]      base_q;
  logic [VA_IMPL-1:0]   va_q;
  logic                 nxe_q;
  logic [ENT_W-1:0]     ent_q;
  fault_e               fault_q;
  psize_e               size_q;
  logic [PA_W-1:0]      paddr_q;

  wire unused_root = ^root_i[PG_SH-1:0];

  // Named internal events for the checker.
  logic walk_idle, rsp_wait, walk_start, rsp_take, step_ok;
  logic e_present, e_rsvd, e_leaf;
  psize_e e_size;

  assign walk_idle  = (state_q == ST_IDLE);
  assign rsp_wait   = (state_q == ST_RD_WAIT);
  assign walk_start = walk_idle && start_i;
  assign rsp_take   = rsp_wait && mem_rsp_valid_i;
  assign step_ok    = rsp_take && e_present && !e_rsvd;

  pt_entry_check #(.PHYS_BITS(PHYS_BITS)) u_chk_ent (
    .entry_i   (mem_rsp_data_i),
    .lvl_i     (lvl_q),
    .nxe_i     (nxe_q),
    .present_o (e_present),
    .rsvd_o    (e_rsvd),
    .leaf_o    (e_leaf),
    .size_o    (e_size)
  );

  pt_attr_acc u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (walk_start),
    .upd_i   (step_ok),
    .user_i  (mem_rsp_data_i[B_USER]),
    .write_i (mem_rsp_data_i[B_WR]),
    .nx_i    (mem_rsp_data_i[B_NX]),
    .user_o  (user_o),
    .write_o (write_o),
    .nx_o    (nx_o)
  );

  assign mem_req_valid_o = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_req_we_o    = (state_q == ST_WR_REQ);
  assign mem_req_addr_o  = tbl_addr(base_q, va_q, lvl_q);
  assign mem_req_wdata_o = ent_q | (ENT_W'(1) << B_ACC);
  assign done_o          = (state_q == ST_FIN);
  assign fault_o         = fault_q;
  assign paddr_o         = paddr_q;
  assign page_size_o     = size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= 2'd0;
      base_q  <= '0;
      va_q    <= '0;
      nxe_q   <= 1'b0;
      ent_q   <= '0;
      fault_q <= FLT_NONE;
      size_q  <= SZ_4K;
      paddr_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          va_q    <= vaddr_i[VA_IMPL-1:0];
          base_q  <= {root_i[PA_W-1:PG_SH], {PG_SH{1'b0}}};
          nxe_q   <= nx_en_i;
          lvl_q   <= 2'd0;
          paddr_q <= '0;
          size_q  <= SZ_4K;
          if (is_canon(vaddr_i)) begin
            fault_q <= FLT_NONE;
            state_q <= ST_RD_REQ;
          end else begin
            fault_q <= FLT_CANON;
            state_q <= ST_FIN;
          end
        end
        ST_RD_REQ: if (mem_req_ready_i) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid_i) begin
          if (!e_present) begin
            fault_q <= FLT_NOTPRES;
            state_q <= ST_FIN;
          end else if (e_rsvd) begin
            fault_q <= FLT_RSVD;
            state_q <= ST_FIN;
          end else if (e_leaf) begin
            size_q  <= e_size;
            paddr_q <= leaf_paddr(mem_rsp_data_i, va_q, e_size);
            state_q <= ST_FIN;
          end else if (!mem_rsp_data_i[B_ACC]) begin
            ent_q   <= mem_rsp_data_i;
            state_q <= ST_WR_REQ;
          end else begin
            base_q  <= {mem_rsp_data_i[PA_W-1:PG_SH], {PG_SH{1'b0}}};
            lvl_q   <= lvl_q + 2'd1;
            state_q <= ST_RD_REQ;
          end
        end
        ST_WR_REQ: if (mem_req_ready_i) begin
          base_q  <= {ent_q[PA_W-1:PG_SH], {PG_SH{1'b0}}};
          lvl_q   <= lvl_q + 2'd1;
          state_q <= ST_RD_REQ;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pt_walker_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [VA_W-1:0]  vaddr_i,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic             mem_req_we_o,
  input logic [PA_W-1:0]  mem_req_addr_o,
  input logic [ENT_W-1:0] mem_req_wdata_o,
  input logic             done_o,
  input logic [1:0]       fault_o,
  input logic [1:0]       page_size_o,
  input logic             walk_idle,
  input logic             rsp_wait
);
  logic va_ok;
  assign va_ok = (&vaddr_i[VA_W-1:VA_IMPL-1]) | ~(|vaddr_i[VA_W-1:VA_IMPL-1]);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_wait_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wait |-> !mem_req_valid_o);
  p_canon_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    walk_idle && start_i && !va_ok |=> done_o && (fault_o == 2'd3) && !mem_req_valid_o);
  p_wb_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && mem_req_we_o |-> mem_req_wdata_o[B_ACC] && mem_req_wdata_o[B_PRES]);
  p_size_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && (fault_o == 2'd0) |-> page_size_o != 2'd3);
  p_addr_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> mem_req_addr_o[2:0] == 3'b000);
endmodule

bind pt_walker pt_walker_chk u_walker_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_i         (start_i),
  .vaddr_i         (vaddr_i),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_we_o    (mem_req_we_o),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_req_wdata_o (mem_req_wdata_o),
  .done_o          (done_o),
  .fault_o         (fault_o),
  .page_size_o     (page_size_o),
  .walk_idle       (walk_idle),
  .rsp_wait        (rsp_wait)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  localparam int PHYS = 46;
  localparam logic [51:0] ROOT = 52'h1000;
  localparam logic [63:0] FP = 64'h1, FW = 64'h2, FU = 64'h4, FA = 64'h20, FS = 64'h80;
  localparam logic [63:0] FN = 64'h8000_0000_0000_0000;
  localparam logic [51:0] T0 = 52'h1000, T1 = 52'h2000, T2 = 52'h3000, T3 = 52'h4000;

  logic clk = 0, rst_n = 0, start = 0, nx_en = 1;
  logic [63:0] vaddr = '0;
  logic req_valid, req_ready = 1, req_we, rsp_valid = 0;
  logic [51:0] req_addr, paddr;
  logic [63:0] req_wdata, rsp_data = '0;
  logic done, user, wr, nx;
  logic [1:0] fault, psize;

  always #10 clk = ~clk;

  pt_walker #(.PHYS_BITS(PHYS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .vaddr_i(vaddr), .root_i(ROOT), .nx_en_i(nx_en),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_we_o(req_we),
    .mem_req_addr_o(req_addr), .mem_req_wdata_o(req_wdata), .mem_rsp_valid_i(rsp_valid),
    .mem_rsp_data_i(rsp_data), .done_o(done), .fault_o(fault), .paddr_o(paddr),
    .page_size_o(psize), .user_o(user), .write_o(wr), .nx_o(nx));

  typedef struct {
    logic [1:0] flt; logic [51:0] pa; logic [1:0] sz; logic u, w, x; int wrs; string tag;
  } exp_t;

  logic [63:0] mem[logic [51:0]];
  logic [63:0] refmem[logic [51:0]];
  logic [51:0] ref_rd[$], obs_rd[$];
  exp_t expq[$];
  int errors = 0, checks = 0, wr_cnt = 0, req_cnt = 0, done_cnt = 0, cyc = 0;
  bit bp = 0, pend = 0;
  logic [51:0] pend_addr;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkva(input int i0, i1, i2, i3, input int off);
    logic [47:0] v;
    v = {i0[8:0], i1[8:0], i2[8:0], i3[8:0], off[11:0]};
    return {{16{v[47]}}, v};
  endfunction

  function automatic logic [63:0] ent(input logic [63:0] a, input logic [63:0] f);
    return (a & 64'h000F_FFFF_FFFF_F000) | f;
  endfunction

  task automatic put(input logic [51:0] a, input logic [63:0] v);
    mem[a] = v; refmem[a] = v;
  endtask

  task automatic clear_tables();
    mem.delete(); refmem.delete();
  endtask

  // Independent model of the walk, written from the requirements.
  task automatic ref_walk(input logic [63:0] va, input bit nxe, output exp_t e);
    logic [51:0] base, a;
    logic [63:0] en, hi;
    logic rsv;
    int sh;
    e.flt = 0; e.pa = 0; e.sz = 0; e.u = 1; e.w = 1; e.x = 0; e.wrs = 0;
    ref_rd.delete();
    hi = va >> 47;
    if (hi != 0 && hi != 64'h1_FFFF) begin e.flt = 3; return; end
    base = ROOT;
    for (int lvl = 0; lvl < 4; lvl++) begin
      sh = 39 - 9 * lvl;
      a = base + 52'(((va >> sh) & 64'h1ff) * 8);
      ref_rd.push_back(a);
      en = refmem.exists(a) ? refmem[a] : 64'h0;
      if (!en[0]) begin e.flt = 1; return; end
      rsv = ((en >> PHYS) & ((64'h1 << (52 - PHYS)) - 1)) != 0;
      if (!nxe && en[63]) rsv = 1;
      if (lvl == 0 && en[7]) rsv = 1;
      if (lvl == 1 && en[7] && ((en >> 13) & 64'h1FFFF) != 0) rsv = 1;
      if (lvl == 2 && en[7] && ((en >> 13) & 64'hFF) != 0) rsv = 1;
      if (rsv) begin e.flt = 2; return; end
      e.u = e.u & en[2]; e.w = e.w & en[1]; e.x = e.x | en[63];
      if (lvl == 3 || (en[7] && lvl > 0)) begin
        sh = (lvl == 1) ? 30 : (lvl == 2) ? 21 : 12;
        e.sz = (lvl == 1) ? 2 : (lvl == 2) ? 1 : 0;
        e.pa = 52'(((en & 64'h000F_FFFF_FFFF_F000) >> sh) << sh) | 52'(va & ((64'h1 << sh) - 1));
        return;
      end
      if (!en[5]) begin refmem[a] = en | 64'h20; e.wrs++; end
      base = 52'(en & 64'h000F_FFFF_FFFF_F000);
    end
  endtask

  // Driver: push expectation, pulse start, wait for the result.
  task automatic run_walk(input logic [63:0] va, input bit nxe, input string tag);
    exp_t e;
    int target;
    ref_walk(va, nxe, e);
    e.tag = tag;
    expq.push_back(e);
    obs_rd.delete(); wr_cnt = 0; req_cnt = 0;
    target = done_cnt + 1;
    @(negedge clk); start = 1; vaddr = va; nx_en = nxe;
    @(negedge clk); start = 0;
    while (done_cnt < target) @(negedge clk);
    @(negedge clk);
    chk(done == 0, "R11 done single pulse", 64'(done), 0);
    begin
      bit same = 1;
      foreach (refmem[k]) if (!mem.exists(k) || mem[k] != refmem[k]) same = 0;
      chk(same, "R8 memory image after write-back", 0, 0);
    end
  endtask

  // Memory responder.
  initial forever begin
    @(negedge clk);
    cyc++;
    req_ready = bp ? cyc[0] : 1'b1;
    if (pend) begin
      rsp_valid = 1; rsp_data = mem.exists(pend_addr) ? mem[pend_addr] : 64'h0; pend = 0;
    end else rsp_valid = 0;
    if (rst_n && req_valid && req_ready) begin
      req_cnt++;
      if (req_we) begin mem[req_addr] = req_wdata; wr_cnt++; end
      else begin pend = 1; pend_addr = req_addr; obs_rd.push_back(req_addr); end
    end
  end

  // Monitor / scoreboard.
  initial forever begin
    @(negedge clk);
    if (rst_n && done) begin
      exp_t e;
      if (expq.size() == 0) chk(0, "R11 unexpected done", 1, 0);
      else begin
        bit rd_same;
        e = expq.pop_front();
        chk(fault == e.flt, {e.tag, " fault code"}, 64'(fault), 64'(e.flt));
        rd_same = (obs_rd.size() == ref_rd.size());
        if (rd_same) foreach (ref_rd[i]) if (obs_rd[i] != ref_rd[i]) rd_same = 0;
        chk(rd_same, "R1 entry read addresses", 64'(obs_rd.size()), 64'(ref_rd.size()));
        chk(wr_cnt == e.wrs, "R8 write-back count", 64'(wr_cnt), 64'(e.wrs));
        if (e.flt == 3) chk(req_cnt == 0, "R2 no memory request", 64'(req_cnt), 0);
        if (e.flt == 0) begin
          chk(paddr == e.pa, "R10 physical address", 64'(paddr), 64'(e.pa));
          chk(psize == e.sz, "R6 page size", 64'(psize), 64'(e.sz));
          chk({user, wr, nx} == {e.u, e.w, e.x}, "R9 merged attributes",
              64'({user, wr, nx}), 64'({e.u, e.w, e.x}));
        end
      end
      done_cnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic tables_4k(input logic [63:0] f, input logic [63:0] lf);
    clear_tables();
    put(T0 + 8,  ent(64'(T1), f));
    put(T1 + 16, ent(64'(T2), f));
    put(T2 + 24, ent(64'(T3), f));
    put(T3 + 32, ent(64'h1234_5000, lf));
  endtask

  initial begin
    logic [63:0] va;
    repeat (3) @(negedge clk);
    chk(req_valid == 0 && done == 0, "R11 reset state", 64'({req_valid, done}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    va = mkva(1, 2, 3, 4, 12'habc);

    tables_4k(FP | FW | FU | FA, FP | FW | FU | FA);
    run_walk(va, 1, "R6");                       // 4 KB, no write-back
    tables_4k(FP | FW | FU, FP | FW | FU);
    run_walk(va, 1, "R8");                       // accessed clear on all non-leaf levels
    tables_4k(FP | FW | FU | FA, FP | FW | FU | FA);
    refmem[T2 + 24] = ent(64'h7_4020_0000, FP | FW | FU | FA | FS); mem[T2 + 24] = refmem[T2 + 24];
    run_walk(va, 1, "R6");                       // 2 MB leaf
    tables_4k(FP | FW | FU, FP | FW | FU | FA);
    refmem[T1 + 16] = ent(64'h80_C000_0000, FP | FW | FU | FS); mem[T1 + 16] = refmem[T1 + 16];
    run_walk(va, 1, "R6");                       // 1 GB leaf, top written back
    tables_4k(FP | FW | FU | FA, FP | FW | FU | FA);
    put(T2 + 24, 64'h0);
    run_walk(va, 1, "R3");                       // not present at level 2
    tables_4k(FP | FW | FU | FA, FP | FW | FU | FA);
    put(T1 + 16, ent(64'h4_0000_0000_3000, FP | FW | FU | FA));
    run_walk(va, 1, "R4");                       // bit 50 above physical width
    tables_4k(FP | FW | FU | FA, FP | FW | FU | FA | FN);
    run_walk(va, 0, "R4");                       // no-execute bit while disabled
    run_walk(va, 1, "R9");                       // no-execute merged as OR
    tables_4k(FP | FW | FU | FA, FP | FW | FU | FA);
    put(T0 + 8, ent(64'(T1), FP | FW | FU | FA | FS));
    run_walk(va, 1, "R5");                       // page size on top level
    tables_4k(FP | FW | FU | FA, FP | FW | FU | FA);
    put(T2 + 24, ent(64'h7_4020_2000, FP | FW | FU | FA | FS));
    run_walk(va, 1, "R7");                       // 2 MB with bit 13 set
    put(T2 + 24, ent(64'h7_4020_1000, FP | FW | FU | FA | FS));
    run_walk(va, 1, "R7");                       // 2 MB with bit 12 accepted
    tables_4k(FP | FW | FU | FA, FP | FW | FU | FA);
    put(T1 + 16, ent(64'h80_E000_0000, FP | FW | FU | FA | FS));
    run_walk(va, 1, "R7");                       // 1 GB with bit 29 set
    tables_4k(FP | FW | FU | FA, FP | FU | FA);
    put(T1 + 16, ent(64'(T2), FP | FW | FA));
    run_walk(va, 1, "R9");                       // user and write cleared by AND
    clear_tables();
    put(T0 + 256 * 8, ent(64'(T1), FP | FW | FU | FA));
    put(T1 + 5 * 8, ent(64'(T2), FP | FW | FU | FA));
    put(T2 + 6 * 8, ent(64'(T3), FP | FW | FU | FA));
    put(T3 + 7 * 8, ent(64'h9_8765_4000, FP | FW | FU | FA));
    run_walk(mkva(256, 5, 6, 7, 12'h123), 1, "R1"); // high-half canonical
    run_walk(64'h0000_8000_0000_0000, 1, "R2");      // non-canonical
    run_walk(64'hFFFF_0000_0000_0000, 1, "R2");      // non-canonical, upper ones short
    bp = 1;
    tables_4k(FP | FW | FU, FP | FW | FU);
    run_walk(va, 1, "R11");                      // stalling request port
    bp = 0;
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R11 all results seen", 64'(expq.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule